// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Block

This block is the control side of a four-channel DMA controller. It decodes byte writes and reads to the upper half of the controller's register index space (indices 8 to 15). It keeps the command, mask, request/terminal-count status and per-channel mode registers. Peripherals drive a request line per channel, and a neighbouring counter block reports terminal counts. The block turns these into a vector of channels that need service. It also gives a single grant, chosen in fixed priority order with channel 0 first.

Address and count registers live in a neighbouring block and are not held here. So is the byte flip-flop that sequences their two halves, and that block receives a one-cycle clear pulse from here. The block does not move any data. The per-channel mode bytes are brought out whole so that the transfer engine can decode the transfer type, auto-init, direction and operating-mode fields itself.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to index 8 loads the command register only when the data has no bit set other than bit 2. Any other data leaves the command unchanged. Command bit 2 set disables the controller, which forces svc_req and svc_grant to zero.
- R2: A write to index 9 picks channel wr_data[1:0]. Its request bit (status bit 4+ch) takes the value of wr_data[2], and its terminal-count bit (status bit ch) is cleared, one cycle later.
- R3: Writes to the mask register. Index 10 sets mask bit wr_data[1:0] to wr_data[2]. Index 14 clears every mask bit. Index 15 loads the mask from wr_data[3:0].
- R4: A write to index 11 stores the whole data byte as the mode of channel wr_data[1:0]. The mode is seen on mode_out[8*ch+7:8*ch] one cycle later, and the other lanes keep their values.
- R5: ff_clear is high in exactly the cycle of a write to index 12 or 13, and low otherwise.
- R6: After rst_n or a write to index 13, the mask reads 0x0F, status reads 0x00 and the command is 0. Mode registers are not touched by an index 13 write.
- R7: A read of index 8 returns status in the same cycle as {request[3:0], tc[3:0]}, and clears the terminal-count nibble on the next edge.
- R8: A read of index 15 returns the mask zero-extended. A read of any other index returns 0.
- R9: A rising dreq edge sets the channel's request bit and a falling edge clears it. In the same cycle, an index 9 write to that channel takes precedence over the edge.
- R10: A tc_done pulse sets the channel's terminal-count bit on the next edge. This wins over a same-cycle clear by a status read or an index 9 write.
- R11: svc_req has a bit set for each channel that is unmasked and has a request pending. svc_grant is one-hot on the lowest-numbered channel in svc_req.
- R12: Writes to indices 0 to 7 change no state in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| port_idx | input | 4 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational while rd_en is high |
| dreq | input | 4 | Peripheral request levels, one per channel |
| tc_done | input | 4 | Terminal-count pulses from the count logic |
| mode_out | output | 32 | Mode bytes, channel n in bits [8n+7:8n] |
| ff_clear | output | 1 | Clear pulse for the byte flip-flop |
| svc_req | output | 4 | Channels that are unmasked with a request pending |
| svc_grant | output | 4 | One-hot fixed-priority choice from svc_req |

## Verification
Read data and ff_clear are combinational, so they are due in the same cycle as the strobe that causes them. Every register effect is due exactly one cycle after its cause: a write, a dreq edge, a tc_done pulse or the clear that a status read triggers. This covers the status, mask, mode, svc_req and svc_grant values. The bench drives its inputs just after a rising edge and tags each expected value with the cycle it is due in. The monitor compares at the following falling edge. Items that reach that edge in the wrong cycle count as failures. The same-cycle collisions are driven on purpose: a tc_done pulse against a status read, and a dreq edge against an index 9 write.

// File: rtl/dmactl_pkg.sv
// Shared definitions for the DMA control register block.
// Assumes: an index space 8..15 for control registers, with the channel select
// in the low data bits and the set/clear flag in data bit 2.
package dmactl_pkg;

    localparam int IDX_W    = 4;
    localparam int FLAG_BIT = 2;

    // Control register indices; their values are fixed by the host decode.
    typedef enum logic [IDX_W-1:0] {
        IX_CMD   = 4'd8,
        IX_SWREQ = 4'd9,
        IX_MASK1 = 4'd10,
        IX_MODE  = 4'd11,
        IX_FFCLR = 4'd12,
        IX_MRST  = 4'd13,
        IX_MCLR  = 4'd14,
        IX_MALL  = 4'd15
    } ctl_idx_e;

    // Only the controller-disable bit of the command byte is accepted.
    localparam logic [7:0] CMD_OK_BITS = 8'h04;

    // One-cycle strobes produced by the decoder.
    typedef struct packed {
        logic cmd_we;
        logic swreq_we;
        logic mask1_we;
        logic mode_we;
        logic ff_clr;
        logic mrst;
        logic mclr;
        logic mall_we;
        logic st_rd;
        logic mask_rd;
    } ctl_strobe_t;

endpackage

// File: rtl/dmactl_decode.sv
// Index decoder: turns a host read or write into one-cycle strobes.
// Assumes: at most one of wr_en / rd_en is meaningful per index; indices 0..7
// belong to another block and produce no strobe here.
module dmactl_decode
    import dmactl_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] port_idx,
    output ctl_strobe_t      st
);

    // Decode the index into write and read strobes.
    always_comb begin
        st = '0;
        if (wr_en) begin
            case (port_idx)
                IX_CMD:   st.cmd_we   = 1'b1;
                IX_SWREQ: st.swreq_we = 1'b1;
                IX_MASK1: st.mask1_we = 1'b1;
                IX_MODE:  st.mode_we  = 1'b1;
                IX_FFCLR: st.ff_clr   = 1'b1;
                IX_MRST: begin
                    st.mrst   = 1'b1;
                    st.ff_clr = 1'b1;
                end
                IX_MCLR:  st.mclr     = 1'b1;
                IX_MALL:  st.mall_we  = 1'b1;
                default:  ;
            endcase
        end
        if (rd_en) begin
            if (port_idx == IX_CMD)  st.st_rd   = 1'b1;
            if (port_idx == IX_MALL) st.mask_rd = 1'b1;
        end
    end

endmodule

// File: rtl/dmactl_ctlregs.sv
// Mask and command registers.
// Assumes: NCH is a power of two not above 2**FLAG_BIT, so the channel select
// fits below the flag bit.
module dmactl_ctlregs
    import dmactl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CSW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctl_strobe_t    st,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] mask_q,
    output logic           ctl_off_q
);

    logic cmd_legal;
    assign cmd_legal = (wr_data & ~DW'(CMD_OK_BITS)) == '0;

    // Mask register: all ones at reset, then the three write forms.
    always_ff @(posedge clk) begin
        if (!rst_n || st.mrst)
            mask_q <= '1;
        else if (st.mclr)
            mask_q <= '0;
        else if (st.mall_we)
            mask_q <= wr_data[NCH-1:0];
        else if (st.mask1_we)
            mask_q[wr_data[CSW-1:0]] <= wr_data[FLAG_BIT];
    end

    // Command register: only the disable bit is stored; other data is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || st.mrst)
            ctl_off_q <= 1'b0;
        else if (st.cmd_we && cmd_legal)
            ctl_off_q <= wr_data[FLAG_BIT];
    end

endmodule

// File: rtl/dmactl_status.sv
// Request and terminal-count status bits per channel.
// Assumes: dreq is already synchronous to clk; tc_done is a one-cycle pulse.
// Priority per channel: reset > software request > dreq edge; tc set > clear.
module dmactl_status
    import dmactl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CSW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctl_strobe_t    st,
    input  logic [DW-1:0]  wr_data,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] tc_done,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] tc_q
);

    logic [NCH-1:0] dreq_d;

    // Previous dreq level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dreq_d <= '0;
        else        dreq_d <= dreq;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        logic r_bit;
        logic t_bit;

        assign hit = st.swreq_we && (wr_data[CSW-1:0] == CSW'(c));

        // Request bit: software write first, then the dreq edges.
        always_ff @(posedge clk) begin
            if (!rst_n || st.mrst)
                r_bit <= 1'b0;
            else if (hit)
                r_bit <= wr_data[FLAG_BIT];
            else if (dreq[c] && !dreq_d[c])
                r_bit <= 1'b1;
            else if (!dreq[c] && dreq_d[c])
                r_bit <= 1'b0;
        end

        // Terminal-count bit: a new pulse beats any clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || st.mrst)
                t_bit <= 1'b0;
            else if (tc_done[c])
                t_bit <= 1'b1;
            else if (hit || st.st_rd)
                t_bit <= 1'b0;
        end

        assign req_q[c] = r_bit;
        assign tc_q[c]  = t_bit;
    end

endmodule

// File: rtl/dmactl_modes.sv
// Per-channel mode byte storage.
// Assumes: the mode byte is kept whole; field decoding belongs to the consumer.
module dmactl_modes
    import dmactl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CSW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctl_strobe_t     st,
    input  logic [DW-1:0]   wr_data,
    output logic [NCH*DW-1:0] mode_flat
);

    for (genvar c = 0; c < NCH; c++) begin : g_mode
        logic [DW-1:0] m_q;

        // Load this lane when the mode write selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                m_q <= '0;
            else if (st.mode_we && (wr_data[CSW-1:0] == CSW'(c)))
                m_q <= wr_data;
        end

        assign mode_flat[c*DW +: DW] = m_q;
    end

endmodule

// File: rtl/dmactl_arbiter.sv
// Service vector and fixed-priority grant, channel 0 highest.
// Assumes: purely combinational; inputs are registered upstream.
module dmactl_arbiter #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] req_q,
    input  logic [NCH-1:0] mask_q,
    input  logic           ctl_off,
    output logic [NCH-1:0] svc,
    output logic [NCH-1:0] grant
);

    logic [NCH:0] taken;

    assign svc      = req_q & ~mask_q & {NCH{~ctl_off}};
    assign taken[0] = 1'b0;

    for (genvar c = 0; c < NCH; c++) begin : g_pri
        assign grant[c]   = svc[c] & ~taken[c];
        assign taken[c+1] = taken[c] | svc[c];
    end

endmodule

// File: rtl/dma_ctl_regs.sv
// Top of the DMA control register block: decode, registers, read mux, arbiter.
// Assumes: NCH <= DW/2 so that status {req, tc} fits in one read byte.
module dma_ctl_regs
    import dmactl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  port_idx,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic [NCH-1:0]    dreq,
    input  logic [NCH-1:0]    tc_done,
    output logic [NCH*DW-1:0] mode_out,
    output logic              ff_clear,
    output logic [NCH-1:0]    svc_req,
    output logic [NCH-1:0]    svc_grant
);

    ctl_strobe_t    st;
    logic [NCH-1:0] mask_vec;
    logic [NCH-1:0] req_vec;
    logic [NCH-1:0] tc_vec;
    logic           ctl_off;

    dmactl_decode u_dec (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .port_idx (port_idx),
        .st       (st)
    );

    dmactl_ctlregs #(.NCH(NCH), .DW(DW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .wr_data   (wr_data),
        .mask_q    (mask_vec),
        .ctl_off_q (ctl_off)
    );

    dmactl_status #(.NCH(NCH), .DW(DW)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .wr_data (wr_data),
        .dreq    (dreq),
        .tc_done (tc_done),
        .req_q   (req_vec),
        .tc_q    (tc_vec)
    );

    dmactl_modes #(.NCH(NCH), .DW(DW)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .wr_data   (wr_data),
        .mode_flat (mode_out)
    );

    dmactl_arbiter #(.NCH(NCH)) u_arb (
        .req_q   (req_vec),
        .mask_q  (mask_vec),
        .ctl_off (ctl_off),
        .svc     (svc_req),
        .grant   (svc_grant)
    );

    assign ff_clear = st.ff_clr;

    // Read mux: status, mask, or zero.
    always_comb begin
        rd_data = '0;
        if (st.st_rd) begin
            rd_data[NCH-1:0]     = tc_vec;
            rd_data[2*NCH-1:NCH] = req_vec;
        end else if (st.mask_rd) begin
            rd_data[NCH-1:0] = mask_vec;
        end
    end

endmodule

// File: rtl/dma_ctl_regs_chk.sv
// Property checker for dma_ctl_regs, attached with bind below.
module dma_ctl_regs_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CSW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           rd_en,
    input logic [3:0]     port_idx,
    input logic [DW-1:0]  wr_data,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] tc_done,
    input logic           ff_clear,
    input logic [NCH-1:0] svc_req,
    input logic [NCH-1:0] svc_grant,
    input logic [NCH-1:0] mask_vec,
    input logic [NCH-1:0] req_vec,
    input logic [NCH-1:0] tc_vec,
    input logic           ctl_off
);

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_grant));

    assert_grant_subset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_grant & ~svc_req) == '0);

    assert_svc_unmasked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req & mask_vec) == '0);

    assert_cmd_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_idx == 4'd8 && (wr_data & ~DW'(8'h04)) != '0) |=> $stable(ctl_off));

    assert_master_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_idx == 4'd13) |=> (mask_vec == '1 && req_vec == '0 && tc_vec == '0 && !ctl_off));

    assert_status_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_idx == 4'd8 && tc_done == '0) |=> tc_vec == '0);

    assert_ffclr_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clear |-> (wr_en && port_idx[3:1] == 3'b110));

    for (genvar c = 0; c < NCH; c++) begin : g_edge
        assert_dreq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(dreq[c]) && !(wr_en && port_idx == 4'd13)
             && !(wr_en && port_idx == 4'd9 && wr_data[CSW-1:0] == CSW'(c)))
            |=> req_vec[c]);

        assert_dreq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(dreq[c])
             && !(wr_en && port_idx == 4'd9 && wr_data[CSW-1:0] == CSW'(c)))
            |=> !req_vec[c]);

        assert_tc_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_done[c] && !(wr_en && port_idx == 4'd13)) |=> tc_vec[c]);
    end

endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_idx  (port_idx),
    .wr_data   (wr_data),
    .dreq      (dreq),
    .tc_done   (tc_done),
    .ff_clear  (ff_clear),
    .svc_req   (svc_req),
    .svc_grant (svc_grant),
    .mask_vec  (mask_vec),
    .req_vec   (req_vec),
    .tc_vec    (tc_vec),
    .ctl_off   (ctl_off)
);

// File: tb/tb_dma_ctl_regs.sv
module tb_dma_ctl_regs;

    localparam int NCH = 4;
    localparam int DW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [3:0]        port_idx = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [DW-1:0]     rd_data;
    logic [NCH-1:0]    dreq = '0;
    logic [NCH-1:0]    tc_done = '0;
    logic [NCH*DW-1:0] mode_out;
    logic              ff_clear;
    logic [NCH-1:0]    svc_req;
    logic [NCH-1:0]    svc_grant;

    dma_ctl_regs #(.NCH(NCH), .DW(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .port_idx  (port_idx),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .dreq      (dreq),
        .tc_done   (tc_done),
        .mode_out  (mode_out),
        .ff_clear  (ff_clear),
        .svc_req   (svc_req),
        .svc_grant (svc_grant)
    );

    always #2 clk = ~clk;

    // Scoreboard item: which output, which lane, expected value, due cycle.
    typedef struct {
        int          due;
        int          sel;
        int          lane;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] sample(input int sel, input int lane);
        case (sel)
            0:       return 32'(rd_data);
            1:       return 32'(ff_clear);
            2:       return 32'(svc_req);
            3:       return 32'(svc_grant);
            default: return 32'(mode_out[lane*DW +: DW]);
        endcase
    endfunction

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = sample(it.sel, it.lane);
            checks++;
            if (it.due != cyc || act != it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d lane=%0d actual=%h expected=%h due=%0d now=%0d",
                         it.tag, it.sel, it.lane, act, it.exp, it.due, cyc);
            end
        end
    end

    task automatic push(input int sel, input int lane, input logic [31:0] exp,
                        input string tag, input int delay);
        item_t it;
        it.due = cyc + delay; it.sel = sel; it.lane = lane; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; tc_done = '0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; rd_en = 1'b0; tc_done = '0; port_idx = idx; wr_data = d;
    endtask

    task automatic wr_dreq(input logic [3:0] idx, input logic [7:0] d, input logic [3:0] q);
        @(posedge clk); #1;
        wr_en = 1'b1; rd_en = 1'b0; tc_done = '0; port_idx = idx; wr_data = d; dreq = q;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b1; tc_done = '0; port_idx = idx;
        push(0, 0, 32'(exp), tag, 0);
    endtask

    task automatic rd_tc(input logic [3:0] idx, input logic [3:0] t,
                         input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b1; tc_done = t; port_idx = idx;
        push(0, 0, 32'(exp), tag, 0);
    endtask

    task automatic set_dreq(input logic [3:0] q);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; tc_done = '0; dreq = q;
    endtask

    task automatic pulse_tc(input logic [3:0] t);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; tc_done = t;
    endtask

    task automatic svc_exp(input logic [3:0] s, input logic [3:0] g,
                           input string tag, input int delay);
        push(2, 0, 32'(s), tag, delay);
        push(3, 0, 32'(g), tag, delay);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R6: reset state.
        rd(4'd15, 8'h0F, "R6 mask after reset");
        rd(4'd8,  8'h00, "R6 status after reset");
        svc_exp(4'h0, 4'h0, "R6 no service after reset", 0);
        push(4, 0, 32'h0, "R6 mode lane0 after reset", 0);

        // R3: full mask write.
        wr(4'd15, 8'h00); idle();
        rd(4'd15, 8'h00, "R3 mask all written");

        // R9/R11: dreq edges raise requests, lowest channel is granted.
        set_dreq(4'b0001); svc_exp(4'b0001, 4'b0001, "R9 dreq0 rise", 1);
        set_dreq(4'b0101); svc_exp(4'b0101, 4'b0001, "R11 priority ch0 over ch2", 1);
        idle();

        // R3/R11: single mask on channel 0.
        wr(4'd10, 8'h04); svc_exp(4'b0100, 4'b0100, "R11 masked ch0", 1); idle();
        rd(4'd8, 8'h50, "R7 status req bits");

        // R1: rejected and accepted command writes.
        wr(4'd8, 8'h01); idle(); svc_exp(4'b0100, 4'b0100, "R1 reject 0x01", 0);
        wr(4'd8, 8'hFC); idle(); svc_exp(4'b0100, 4'b0100, "R1 reject 0xFC", 0);
        wr(4'd8, 8'h04); idle(); svc_exp(4'b0000, 4'b0000, "R1 disable accepted", 0);
        wr(4'd8, 8'h00); idle(); svc_exp(4'b0100, 4'b0100, "R1 enable again", 0);

        // R10/R7: terminal count set, read and cleared.
        pulse_tc(4'b0010); idle();
        rd(4'd8, 8'h52, "R10 tc1 set");
        rd(4'd8, 8'h50, "R7 tc cleared by read");
        rd_tc(4'd8, 4'b1000, 8'h50, "R7 read with tc3 pulse");
        rd(4'd8, 8'h58, "R10 tc pulse beats read clear");
        rd(4'd8, 8'h50, "R7 cleared again");

        // R2: software requests.
        wr(4'd9, 8'h07); svc_exp(4'b1100, 4'b0100, "R2 sw set ch3", 1); idle();
        wr(4'd9, 8'h02); svc_exp(4'b1000, 4'b1000, "R2 sw clear ch2", 1); idle();
        rd(4'd8, 8'h90, "R2 status after sw writes");
        pulse_tc(4'b1000);
        wr(4'd9, 8'h03); idle();
        rd(4'd8, 8'h10, "R2 sw write clears req3 and tc3");

        // R9: software write wins over a same-cycle dreq rise; a fall clears.
        wr_dreq(4'd9, 8'h01, 4'b0111); idle();
        rd(4'd8, 8'h10, "R9 sw write beats dreq1 rise");
        set_dreq(4'b0110); idle();
        rd(4'd8, 8'h00, "R9 dreq0 fall clears");

        // R4: mode writes into their lanes.
        wr(4'd11, 8'hA6); push(4, 2, 32'hA6, "R4 mode ch2", 1); idle();
        wr(4'd11, 8'h59);
        push(4, 1, 32'h59, "R4 mode ch1", 1);
        push(4, 2, 32'hA6, "R4 mode ch2 kept", 1);
        idle();

        // R5: flip-flop clear pulse.
        wr(4'd12, 8'h00);
        push(1, 0, 32'h1, "R5 ff_clear on index 12", 0);
        push(1, 0, 32'h0, "R5 ff_clear drops", 1);
        idle();

        // R12/R8: unknown index writes and other reads.
        wr(4'd3, 8'hFF); idle();
        rd(4'd15, 8'h01, "R12 mask unchanged");
        rd(4'd8,  8'h00, "R12 status unchanged");
        rd(4'd5,  8'h00, "R8 other index reads zero");
        rd(4'd15, 8'h01, "R8 mask readback");

        // R3: clear-all and single mask writes.
        wr(4'd14, 8'h00); idle();
        rd(4'd15, 8'h00, "R3 clear all masks");
        wr(4'd10, 8'h05); idle();
        rd(4'd15, 8'h02, "R3 single mask ch1");
        wr(4'd15, 8'hF9); idle();
        rd(4'd15, 8'h09, "R3 full mask low nibble");

        // R6: master reset clears status and mask but keeps modes.
        pulse_tc(4'b0001);
        set_dreq(4'b0111); idle();
        rd(4'd8, 8'h11, "R9 dreq0 rise before master reset");
        wr(4'd13, 8'h00); push(1, 0, 32'h1, "R5 ff_clear on index 13", 0); idle();
        rd(4'd15, 8'h0F, "R6 mask after master reset");
        rd(4'd8,  8'h00, "R6 status after master reset");
        push(4, 1, 32'h59, "R6 mode kept after master reset", 0);
        svc_exp(4'b0000, 4'b0000, "R6 no service after master reset", 0);
        idle();

        repeat (3) @(posedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items", sbq.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule